// File: doc/BRIEF.md
# Monochrome Video Scanout Engine

This block turns a single master pixel clock into a complete monochrome raster. A line counter and a frame counter produce active-low horizontal and vertical sync and a video-active window. A small phase counter divides the master clock into three slower bus phases, with ratios of 1/2, 1/4 and 1/8. The phase counter restarts on the first clock of every line, so the bus phases always line up with the pixel grid.

Inside the active window the engine fetches one frame-buffer byte every eight pixels. Each fetch lands in a fixed slot of the 1/8 bus phase. The fetched byte is loaded into a shift register and sent out one bit per master clock, most significant bit first. The single pixel bit drives all three colour outputs together.

The byte address points into an 8 KiB frame buffer whose bus page is fixed. It steps by one per fetch. Each stored row of bytes can be shown on several consecutive scan lines. The address goes back to zero at every frame.

Top module: `mono_scanout`

## Requirements
- R1: While rst_ni is low, every output holds its line-zero, frame-zero value: phase_o is 0, hsync_o and vsync_o are 0, vid_active_o and pixel_o are 0, and vid_addr_o is 16'h2000. The phase stays at 0 for as long as rst_ni is held low.
- R2: phase_o equals the line position modulo 8. Bit 0 is the 1/2 phase, bit 1 the 1/4 phase and bit 2 the 1/8 phase. The counter restarts at 0 on the first clock of every line, even when H_TOTAL is not a multiple of 8.
- R3: Each line lasts H_TOTAL clocks. hsync_o is low for line positions 0 to H_SYNC-1 and high for the rest of the line.
- R4: Each frame lasts V_TOTAL lines. vsync_o is low during lines 0 to V_SYNC-1 and high for the rest of the frame.
- R5: vid_active_o is high exactly when the line position lies in [H_START, H_START+H_ACTIVE) and the line number lies in [V_START, V_START+V_ACTIVE).
- R6: A byte is loaded in every active clock whose phase is 3'b011, meaning the 1/2 and 1/4 phases are high and the 1/8 phase is low. That gives exactly one load per 8 pixels. data_i is sampled in that clock. Its bit 7 appears on pixel_o in the next clock, then bits 6 down to 0 in the following clocks, one bit per clock.
- R7: pixel_o is 0 in every clock that is not one of the 8 clocks fed by a load, including all of blanking.
- R8: rgb_o is {pixel_o, pixel_o, pixel_o} in every clock.
- R9: vid_addr_o[15:13] is always 3'b001. During a load clock, vid_addr_o[12:0] equals row*(H_ACTIVE/8) plus the byte index within the line, and it steps by one after each load.
- R10: Each frame-buffer row is shown on LINE_REP consecutive active lines. The address goes back to the start of the row for each repeat, and it advances to the next row only after the last repeat.
- R11: The address returns to zero at every frame start, so the second and later frames fetch the same addresses as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset and ready; holds the phase counter cleared |
| data_i | input | 8 | Frame-buffer byte at vid_addr_o |
| vid_addr_o | output | 16 | Frame-buffer bus address, page bits fixed at 3'b001 |
| phase_o | output | 3 | Bus phase clocks: bit 0 is 1/2, bit 1 is 1/4, bit 2 is 1/8 |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| vid_active_o | output | 1 | High inside the visible window |
| pixel_o | output | 1 | Serial pixel bit |
| rgb_o | output | 3 | Pixel bit replicated to the three colour channels |

## Verification
The frame buffer is modelled as a byte pattern that depends on the address. A wrong fetch address or a skipped fetch therefore shows up as wrong pixels, not only as a wrong address. The geometry is shrunk and H_TOTAL is deliberately not a multiple of 8, so a phase counter that fails to restart at each line shifts every fetch slot and is caught.

The run covers more than two frames with a line repetition of 2. This separates three cases:
- a correct row repeat from an address that keeps running on;
- a frame restart from an address that wraps only on overflow;
- the first repeat of a row from the later ones.

A second reset in mid-frame checks that the bit queue and the counters start again cleanly.

// File: rtl/mono_scanout_pkg.sv
package mono_scanout_pkg;
  localparam int unsigned FB_ADDR_W = 13;
  localparam logic [2:0]  FB_PAGE   = 3'b001;
  localparam logic [2:0]  LOAD_SLOT = 3'b011;
  typedef logic [FB_ADDR_W-1:0] fb_addr_t;
endpackage

// File: rtl/mono_phase_div.sv
module mono_phase_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [DIV_W-1:0] div_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  assign div_o = div_q;
endmodule

// File: rtl/mono_sync_gen.sv
module mono_sync_gen #(
  parameter int unsigned H_TOTAL  = 409,
  parameter int unsigned H_SYNC   = 9,
  parameter int unsigned H_START  = 64,
  parameter int unsigned H_ACTIVE = 256,
  parameter int unsigned V_TOTAL  = 585,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_START  = 40,
  parameter int unsigned V_ACTIVE = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hsync_o,
  output logic vsync_o,
  output logic active_o,
  output logic line_wrap_o,
  output logic frame_wrap_o,
  output logic line_done_o
);
  localparam int unsigned HW = $clog2(H_TOTAL + 1);
  localparam int unsigned VW = $clog2(V_TOTAL + 1);
  localparam logic [HW-1:0] H_LAST_C  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_SYNC_C  = HW'(H_SYNC);
  localparam logic [HW-1:0] H_START_C = HW'(H_START);
  localparam logic [HW-1:0] H_STOP_C  = HW'(H_START + H_ACTIVE);
  localparam logic [HW-1:0] H_DONE_C  = HW'(H_START + H_ACTIVE - 1);
  localparam logic [VW-1:0] V_LAST_C  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_SYNC_C  = VW'(V_SYNC);
  localparam logic [VW-1:0] V_START_C = VW'(V_START);
  localparam logic [VW-1:0] V_STOP_C  = VW'(V_START + V_ACTIVE);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic h_win, v_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST_C) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST_C) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_win        = (h_q >= H_START_C) && (h_q < H_STOP_C);
  assign v_win        = (v_q >= V_START_C) && (v_q < V_STOP_C);
  assign hsync_o      = (h_q >= H_SYNC_C);
  assign vsync_o      = (v_q >= V_SYNC_C);
  assign active_o     = h_win && v_win;
  assign line_wrap_o  = (h_q == H_LAST_C);
  assign frame_wrap_o = line_wrap_o && (v_q == V_LAST_C);
  assign line_done_o  = (h_q == H_DONE_C) && v_win;

  // R3
  hsync_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !active_o);
  // R4
  vsync_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> !active_o);
endmodule

// File: rtl/mono_addr_gen.sv
module mono_addr_gen
  import mono_scanout_pkg::*;
#(
  parameter int unsigned LINE_REP = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  logic     line_done_i,
  input  logic     frame_wrap_i,
  output fb_addr_t addr_o
);
  localparam int unsigned RW = (LINE_REP > 1) ? $clog2(LINE_REP) : 1;
  localparam logic [RW-1:0] REP_LAST_C = RW'(LINE_REP - 1);

  fb_addr_t      addr_q, base_q;
  logic [RW-1:0] rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
      rep_q  <= '0;
    end else if (frame_wrap_i) begin
      addr_q <= '0;
      base_q <= '0;
      rep_q  <= '0;
    end else if (line_done_i) begin
      if (rep_q == REP_LAST_C) begin
        base_q <= addr_q;   // next row starts where this one ended
        rep_q  <= '0;
      end else begin
        addr_q <= base_q;   // redisplay the same row
        rep_q  <= rep_q + 1'b1;
      end
    end else if (load_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

  // R9
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_q == $past(addr_q) + fb_addr_t'(1));
  // R11
  frame_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap_i |=> (addr_q == '0) && (rep_q == '0));
endmodule

// File: rtl/mono_pix_shift.sv
module mono_pix_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       pix_o
);
  logic [7:0] sr_q;
  logic [3:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= data_i;
      left_q <= 4'd8;
    end else begin
      sr_q <= {sr_q[6:0], 1'b0};
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  // blanking gate: only bits fed by a load reach the output
  assign pix_o = sr_q[7] && (left_q != '0);

  // R6
  load_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> left_q <= 4'd1);
endmodule

// File: rtl/mono_scanout.sv
module mono_scanout
  import mono_scanout_pkg::*;
#(
  parameter int unsigned H_TOTAL  = 409,
  parameter int unsigned H_SYNC   = 9,
  parameter int unsigned H_START  = 64,
  parameter int unsigned H_ACTIVE = 256,
  parameter int unsigned V_TOTAL  = 585,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_START  = 40,
  parameter int unsigned V_ACTIVE = 512,
  parameter int unsigned LINE_REP = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  data_i,
  output logic [15:0] vid_addr_o,
  output logic [2:0]  phase_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        vid_active_o,
  output logic        pixel_o,
  output logic [2:0]  rgb_o
);
  // H_START must be a multiple of 8 so the load slot sits inside each byte cell
  logic       line_wrap, frame_wrap, line_done, active, load;
  logic [2:0] div;
  fb_addr_t   fb_addr;
  logic       pix;

  mono_sync_gen #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_START(H_START), .H_ACTIVE(H_ACTIVE),
    .V_TOTAL(V_TOTAL), .V_SYNC(V_SYNC), .V_START(V_START), .V_ACTIVE(V_ACTIVE)
  ) u_sync (
    .clk_i, .rst_ni,
    .hsync_o, .vsync_o,
    .active_o     (active),
    .line_wrap_o  (line_wrap),
    .frame_wrap_o (frame_wrap),
    .line_done_o  (line_done)
  );

  mono_phase_div #(.DIV_W(3)) u_div (
    .clk_i, .rst_ni,
    .restart_i (line_wrap),
    .div_o     (div)
  );

  assign load = active && (div == LOAD_SLOT);

  mono_addr_gen #(.LINE_REP(LINE_REP)) u_addr (
    .clk_i, .rst_ni,
    .load_i       (load),
    .line_done_i  (line_done),
    .frame_wrap_i (frame_wrap),
    .addr_o       (fb_addr)
  );

  mono_pix_shift u_shift (
    .clk_i, .rst_ni,
    .load_i (load),
    .data_i,
    .pix_o  (pix)
  );

  assign vid_addr_o   = {FB_PAGE, fb_addr};
  assign phase_o      = div;
  assign vid_active_o = active;
  assign pixel_o      = pix;
  assign rgb_o        = {3{pix}};

  // R2
  phase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_active_o) |-> phase_o == 3'd0);
  // R7
  blank_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_o || !vsync_o) |-> !pixel_o);
endmodule

// File: tb/mono_scanout_test.sv
module mono_scanout_test;
  localparam int HT = 60, HS = 4, HST = 16, HA = 32;
  localparam int VT = 20, VS = 2, VST = 4, VA = 8, REP = 2;
  localparam int BPL = HA / 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data;
  logic [15:0] vid_addr;
  logic [2:0]  phase, rgb;
  logic        hsync, vsync, vact, pixel;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int bh = 0, bv = 0, bframe = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  mono_scanout #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_START(HST), .H_ACTIVE(HA),
    .V_TOTAL(VT), .V_SYNC(VS), .V_START(VST), .V_ACTIVE(VA), .LINE_REP(REP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .vid_addr_o(vid_addr),
    .phase_o(phase), .hsync_o(hsync), .vsync_o(vsync), .vid_active_o(vact),
    .pixel_o(pixel), .rgb_o(rgb)
  );

  function automatic logic [7:0] mem(input int a);
    return 8'((a * 29 + 90) & 255);
  endfunction

  always_comb data = mem(int'(vid_addr[12:0]));

  function automatic bit in_win(input int h, input int v);
    return h >= HST && h < HST + HA && v >= VST && v < VST + VA;
  endfunction

  function automatic int exp_addr(input int h, input int v);
    return ((v - VST) / REP) * BPL + (h - HST) / 8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (h=%0d v=%0d)", req, act, exp, bh, bv);
    end
  endtask

  // driver side: push the 8 expected bits of a byte, MSB first
  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
  endtask

  // position model: R3/R4 periods
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bh <= 0; bv <= 0;
    end else if (bh == HT - 1) begin
      bh <= 0;
      if (bv == VT - 1) begin bv <= 0; bframe <= bframe + 1; end
      else bv <= bv + 1;
    end else bh <= bh + 1;
  end

  // monitor
  always @(negedge clk) begin
    string t;
    bit ep;
    if (!rst_n) exp_q.delete();
    t = rst_n ? "R3" : "R1";
    chk(hsync == (bh >= HS), t, hsync, bh >= HS);
    t = rst_n ? "R4" : "R1";
    chk(vsync == (bv >= VS), t, vsync, bv >= VS);
    t = rst_n ? "R5" : "R1";
    chk(vact == in_win(bh, bv), t, vact, in_win(bh, bv));
    t = rst_n ? "R2" : "R1";
    chk(phase == 3'(bh % 8), t, phase, bh % 8);
    chk(vid_addr[15:13] == 3'b001, "R9", vid_addr[15:13], 1);
    if (!rst_n) chk(vid_addr == 16'h2000, "R1", vid_addr, 16'h2000);
    if (exp_q.size() != 0) begin
      ep = exp_q.pop_front();
      chk(pixel == ep, "R6", pixel, ep);
    end else begin
      ep = 1'b0;
      t = rst_n ? "R7" : "R1";
      chk(pixel == 1'b0, t, pixel, 0);
    end
    chk(rgb == {3{pixel}}, "R8", rgb, {3{pixel}});
    if (rst_n && in_win(bh, bv) && (bh % 8) == 3) begin
      if (bframe > 0 && bv < VST + REP) t = "R11";
      else if (((bv - VST) % REP) != 0) t = "R10";
      else t = "R9";
      chk(vid_addr[12:0] == 13'(exp_addr(bh, bv)), t, vid_addr[12:0], exp_addr(bh, bv));
      push_byte(mem(exp_addr(bh, bv)));
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: hold reset several cycles, phase must stay cleared
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // more than two frames: row repeat (R10), frame restart (R11)
    repeat (VT * HT * 2 + HT * 9) @(negedge clk);
    #3 rst_n = 1'b0;   // mid-frame reset, R1
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (HT * VT + 100) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule